// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous multi-port memory. It holds an internal burst counter. The counter can be loaded from the port's address bus, advanced by one per clock, cleared, or held. A mask register, loaded from the same bus, sets how many low-order bits take part in counting. Only that low field advances and wraps. The bits above it keep the value they were loaded with. A one-cycle flag marks each wrap of the counted field from all ones back to zero.

The address the memory uses in a cycle is the registered counter value. A load therefore shows up as the external address one clock after it is requested. The host can ask for the counter or the mask to be driven back onto the shared address lines. The returned value appears one clock after the request, together with an output enable that tells the pad logic to turn the bus around. The master reset is synchronous and active high.

Top module: `burst_addr_gen`

## Requirements
- R1: After master reset the address output is 0, the wrap flag and readback enable are low, and the mask is all ones (16'hFFFF when read back).
- R2: With `cnt_load_n` low and no clear or mask load in that cycle, `addr_out` equals the sampled `addr_in` one clock later.
- R3: With `cnt_inc` high and no clear, mask load or counter load, the counted field of `addr_out` advances by one on each rising edge.
- R4: When counter load and increment are requested in the same cycle, the load wins and the loaded value is not incremented.
- R5: Under mask M, an increment changes only the bits set in M. When those bits are all ones they become zero, and the bits outside M keep their value.
- R6: `wrap_flag` is high for exactly the one cycle following an increment edge at which the counted field wrapped. It is never high with a zero mask.
- R7: `cnt_clr` clears the counter at the next edge and overrides load, mask load and increment. It leaves the mask unchanged.
- R8: A mask load stores the run of ones of `addr_in` that starts at bit 0. Bit i of the mask is set only if bits i down to 0 of `addr_in` are all set. A mask load blocks a counter load or increment in the same cycle, and the counter holds.
- R9: A readback request sets `rb_oe` high for the following cycle. In that cycle `rb_data` holds the counter value from before the request edge, or the mask for `rb_mask`. The counter wins if both are requested. `rb_oe` is low in any cycle that follows no request.
- R10: With no command the counter holds. With a zero mask an increment leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high master reset |
| addr_in | input | AW | External address or mask value from the host |
| cnt_load_n | input | 1 | Active-low counter load request |
| cnt_inc | input | 1 | Counter advance request |
| cnt_clr | input | 1 | Synchronous counter clear |
| mask_load | input | 1 | Load the mask register from `addr_in` |
| rb_cnt | input | 1 | Request readback of the counter |
| rb_mask | input | 1 | Request readback of the mask |
| addr_out | output | AW | Address used by the memory this cycle |
| wrap_flag | output | 1 | One-cycle pulse after the counted field wraps |
| rb_data | output | AW | Value to drive onto the address lines |
| rb_oe | output | 1 | Drive enable for `rb_data` |

## Verification
The hardest state to reach from the ports is a wrap of a narrow field while the upper bits hold a nonzero pattern. Reaching it takes a mask load, then a counter load that puts the field at all ones under that mask, then one increment. The stimulus reaches this state twice with different masks. It also covers the case where the mask was cleaned from a non-contiguous bus value, and it confirms that a zero mask suppresses both counting and the flag. Readback of the pre-update counter is driven in the same cycle as an increment, so a capture taken after the update would be exposed.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/burst_ctl_dec.sv
module burst_ctl_dec
  import burst_addr_pkg::*;
(
  input  logic    cnt_load_n,
  input  logic    cnt_inc,
  input  logic    cnt_clr,
  input  logic    mask_load,
  output cnt_op_e op,
  output logic    mask_we
);
  // priority: clear, mask load (counter holds), load, increment, hold
  always_comb begin
    mask_we = 1'b0;
    op      = OP_HOLD;
    if (cnt_clr) begin
      op = OP_CLR;
    end else if (mask_load) begin
      mask_we = 1'b1;
    end else if (!cnt_load_n) begin
      op = OP_LOAD;
    end else if (cnt_inc) begin
      op = OP_INC;
    end
  end
endmodule

// File: rtl/burst_mask_reg.sv
module burst_mask_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] mask
);
  localparam logic [AW-1:0] MASK_ALL = {AW{1'b1}};

  logic [AW-1:0] clean;

  // keep only the run of ones anchored at bit 0
  for (genvar i = 0; i < AW; i++) begin : g_clean
    assign clean[i] = &din[i:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     mask <= MASK_ALL;
    else if (we) mask <= clean;
  end

  // R8: stored mask is always a contiguous low run
  p_mask_contig_r8: assert property (@(posedge clk) disable iff (rst)
    ((mask + 1'b1) & mask) == '0);
  p_mask_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> mask == $past(mask));
endmodule

// File: rtl/burst_cnt_core.sv
module burst_cnt_core
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cnt_op_e       op,
  input  logic [AW-1:0] din,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] cnt,
  output logic          wrap
);
  logic [AW-1:0] field;
  logic [AW-1:0] inc_val;
  logic          wrap_now;

  assign field    = cnt & mask;
  assign inc_val  = (cnt & ~mask) | ((cnt + 1'b1) & mask);
  assign wrap_now = (op == OP_INC) && (mask != '0) && (field == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= wrap_now;
      unique case (op)
        OP_CLR:  cnt <= '0;
        OP_LOAD: cnt <= din;
        OP_INC:  cnt <= inc_val;
        default: cnt <= cnt;
      endcase
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> cnt == $past(din));
  p_clr_r7: assert property (@(posedge clk) disable iff (rst)
    op == OP_CLR |=> cnt == '0);
  p_upper_hold_r5: assert property (@(posedge clk) disable iff (rst)
    op == OP_INC |=> (cnt & ~$past(mask)) == ($past(cnt) & ~$past(mask)));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> $stable(cnt));
  p_flag_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);
  p_flag_zero_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |-> cnt == $past(cnt & ~mask));
endmodule

// File: rtl/burst_readback.sv
module burst_readback #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rb_cnt,
  input  logic          rb_mask,
  input  logic [AW-1:0] cnt,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] rb_data,
  output logic          rb_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rb_data <= '0;
      rb_oe   <= 1'b0;
    end else begin
      rb_oe <= rb_cnt | rb_mask;
      if (rb_cnt)       rb_data <= cnt;
      else if (rb_mask) rb_data <= mask;
    end
  end

  p_rb_on_r9: assert property (@(posedge clk) disable iff (rst)
    (rb_cnt | rb_mask) |=> rb_oe);
  p_rb_off_r9: assert property (@(posedge clk) disable iff (rst)
    !(rb_cnt | rb_mask) |=> !rb_oe);
  p_rb_cnt_r9: assert property (@(posedge clk) disable iff (rst)
    rb_cnt |=> rb_data == $past(cnt));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          cnt_load_n,
  input  logic          cnt_inc,
  input  logic          cnt_clr,
  input  logic          mask_load,
  input  logic          rb_cnt,
  input  logic          rb_mask,
  output logic [AW-1:0] addr_out,
  output logic          wrap_flag,
  output logic [AW-1:0] rb_data,
  output logic          rb_oe
);
  cnt_op_e       op;
  logic          mask_we;
  logic [AW-1:0] mask;
  logic [AW-1:0] cnt;

  burst_ctl_dec u_dec (
    .cnt_load_n (cnt_load_n),
    .cnt_inc    (cnt_inc),
    .cnt_clr    (cnt_clr),
    .mask_load  (mask_load),
    .op         (op),
    .mask_we    (mask_we)
  );

  burst_mask_reg #(.AW(AW)) u_mask (
    .clk  (clk),
    .rst  (rst),
    .we   (mask_we),
    .din  (addr_in),
    .mask (mask)
  );

  burst_cnt_core #(.AW(AW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .op   (op),
    .din  (addr_in),
    .mask (mask),
    .cnt  (cnt),
    .wrap (wrap_flag)
  );

  burst_readback #(.AW(AW)) u_rb (
    .clk     (clk),
    .rst     (rst),
    .rb_cnt  (rb_cnt),
    .rb_mask (rb_mask),
    .cnt     (cnt),
    .mask    (mask),
    .rb_data (rb_data),
    .rb_oe   (rb_oe)
  );

  assign addr_out = cnt;

  // R4: load beats increment at the ports
  p_load_over_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (!cnt_load_n && cnt_inc && !cnt_clr && !mask_load) |=> addr_out == $past(addr_in));
  // R7: clear overrides everything
  p_clr_top_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> addr_out == '0);
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 16;
  localparam int NV = 20;

  typedef struct packed {
    logic       ld_n, inc, clr, mld, rbc, rbm;
    logic [15:0] din;
    logic [15:0] e_addr;
    logic       e_wrap, e_oe;
    logic [15:0] e_rb;
    logic [3:0] req;
  } vec_t;

  // ld_n inc clr mld rbc rbm din e_addr wrap oe rb req
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h1234,16'h1234,1'b0,1'b0,16'h0000,4'd2},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h1235,1'b0,1'b0,16'h0000,4'd3},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h1236,1'b0,1'b0,16'h0000,4'd3},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h00FE,16'h00FE,1'b0,1'b0,16'h0000,4'd4},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h00FF,1'b0,1'b0,16'h0000,4'd3},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h000F,16'h00FF,1'b0,1'b0,16'h0000,4'd8},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h00FF,1'b0,1'b1,16'h000F,4'd9},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h00F0,1'b1,1'b0,16'h0000,4'd5},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h00F1,1'b0,1'b0,16'h0000,4'd6},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h00F2,1'b0,1'b1,16'h00F1,4'd9},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h00F2,1'b0,1'b0,16'h0000,4'd10},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'hABCD,16'h0000,1'b0,1'b0,16'h0000,4'd7},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b1,16'h000F,4'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'h00F7,16'h0000,1'b0,1'b0,16'h0000,4'd8},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b1,16'h0007,4'd8},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h5557,16'h5557,1'b0,1'b0,16'h0000,4'd2},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h5550,1'b1,1'b0,16'h0000,4'd5},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h5550,1'b0,1'b0,16'h0000,4'd8},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h5550,1'b0,1'b0,16'h0000,4'd10},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,16'h0000,16'h5550,1'b0,1'b1,16'h5550,4'd9}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          cnt_load_n = 1'b1;
  logic          cnt_inc = 1'b0;
  logic          cnt_clr = 1'b0;
  logic          mask_load = 1'b0;
  logic          rb_cnt = 1'b0;
  logic          rb_mask = 1'b0;
  logic [AW-1:0] addr_out;
  logic          wrap_flag;
  logic [AW-1:0] rb_data;
  logic          rb_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .addr_in(addr_in), .cnt_load_n(cnt_load_n),
    .cnt_inc(cnt_inc), .cnt_clr(cnt_clr), .mask_load(mask_load),
    .rb_cnt(rb_cnt), .rb_mask(rb_mask), .addr_out(addr_out),
    .wrap_flag(wrap_flag), .rb_data(rb_data), .rb_oe(rb_oe)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string what, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ld_n, input logic inc, input logic clr,
                       input logic mld, input logic rbc, input logic rbm,
                       input logic [15:0] din);
    cnt_load_n = ld_n; cnt_inc = inc; cnt_clr = clr;
    mask_load = mld; rb_cnt = rbc; rb_mask = rbm; addr_in = din;
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset state
    check("addr after reset", "R1", addr_out, 0);
    check("wrap after reset", "R1", wrap_flag, 0);
    check("oe after reset", "R1", rb_oe, 0);
    drive(1, 0, 0, 0, 0, 1, 16'h0);
    check("mask after reset", "R1", rb_data, 32'hFFFF);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ld_n, VEC[i].inc, VEC[i].clr, VEC[i].mld,
            VEC[i].rbc, VEC[i].rbm, VEC[i].din);
      check($sformatf("vec%0d addr", i), req_name(VEC[i].req), addr_out, VEC[i].e_addr);
      check($sformatf("vec%0d wrap", i), req_name(VEC[i].req), wrap_flag, VEC[i].e_wrap);
      check($sformatf("vec%0d oe", i), req_name(VEC[i].req), rb_oe, VEC[i].e_oe);
      if (VEC[i].e_oe)
        check($sformatf("vec%0d rb", i), req_name(VEC[i].req), rb_data, VEC[i].e_rb);
    end

    // R1: master reset in the middle of activity, with commands present
    rst = 1'b1;
    drive(0, 1, 0, 0, 1, 0, 16'h7777);
    rst = 1'b0;
    check("addr mid reset", "R1", addr_out, 0);
    check("wrap mid reset", "R1", wrap_flag, 0);
    check("oe mid reset", "R1", rb_oe, 0);
    drive(1, 0, 0, 0, 0, 1, 16'h0);
    check("mask restored", "R1", rb_data, 32'hFFFF);

    // R5 / R6: full-width wrap with the default mask
    drive(0, 0, 0, 0, 0, 0, 16'hFFFF);
    check("load ffff", "R2", addr_out, 32'hFFFF);
    drive(1, 1, 0, 0, 0, 0, 16'h0);
    check("full wrap addr", "R5", addr_out, 0);
    check("full wrap flag", "R6", wrap_flag, 1);
    drive(1, 0, 0, 0, 0, 0, 16'h0);
    check("flag drops", "R6", wrap_flag, 0);
    check("hold after wrap", "R10", addr_out, 0);

    // R8: one-bit mask; counter wraps every second increment
    drive(1, 0, 0, 1, 0, 0, 16'h0001);
    drive(0, 0, 0, 0, 0, 0, 16'h8000);
    drive(1, 1, 0, 0, 0, 0, 16'h0);
    check("1-bit field up", "R5", addr_out, 32'h8001);
    check("1-bit no flag", "R6", wrap_flag, 0);
    drive(1, 1, 0, 0, 0, 0, 16'h0);
    check("1-bit wrap", "R5", addr_out, 32'h8000);
    check("1-bit flag", "R6", wrap_flag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule